// File: doc/BRIEF.md
# Aggressive Device-Sleep Port Controller

This block sits beside one serial storage host port and decides on its own when to drive the device-sleep pin to the drive. It watches a millisecond tick, an idle indication from the link layer and a per-command strobe. When the link has stayed idle for a programmed number of milliseconds, it raises the pin. When a new command shows up, it lowers the pin again and raises a one-cycle wake request toward the link layer. It then holds off for a programmed recovery time before it reports the link as ready.

A single 32-bit control word sets the policy. Software can flip the enable bit whenever it likes. The timing fields only take new values while the command engine is stopped. Two build-time straps tune the block:
- one says whether the port wires out a device-sleep pin at all;
- the other restricts entry to times when the link is in its deepest low-power state, not merely idle.

Top module: `dslp_port_ctrl`

## Requirements
- R1: After reset `dev_sleep` and `wake_req` are 0, `link_ready` is 1, and `reg_rdata` shows enable 0 with the timing fields at their parameter defaults.
- R2: `reg_rdata` layout: bit 0 enable, bit 1 pin-present strap (read-only), bits 9:2 exit time, bits 14:10 minimum assertion time, bits 24:15 idle time, bits 28:25 idle multiplier; bits 31:29 read 0.
- R3: A write while `engine_run` is 1 leaves four fields unchanged: exit time, minimum assertion time, idle time and multiplier. A write while `engine_run` is 0 updates them.
- R4: The enable bit takes the written value on every write, whatever `engine_run` holds.
- R5: With enable 1, `dev_sleep` rises after idle time × (multiplier + 1) uninterrupted qualifying `ms_tick` pulses. An idle time of 0 never causes entry.
- R6: In the awake state, a `cmd_issue` strobe or a drop of `link_idle` restarts the idle count from zero.
- R7: With the present strap at 0, `dev_sleep` never rises and bit 1 reads 0.
- R8: With the slumber-only strap at 1, idle ticks count only while `link_slumber` is 1.
- R9: A `cmd_issue` while `dev_sleep` is 1 lowers it once the pin has been high for the minimum assertion time in ticks (at once if that time is 0). `wake_req` is pulsed for exactly the one cycle in which the pin drops.
- R10: After `dev_sleep` falls, `link_ready` stays 0 for the exit time in ticks, and no re-entry happens in that window.
- R11: Clearing enable while asleep lowers `dev_sleep` after the minimum assertion time, without `wake_req`, then passes through the exit window back to the awake state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| engine_run | input | 1 | Command engine running; locks timing fields |
| link_idle | input | 1 | Link has no traffic |
| link_slumber | input | 1 | Link is in its deepest low-power state |
| cmd_issue | input | 1 | One-cycle strobe per new command |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| dev_sleep | output | 1 | Device-sleep pin |
| wake_req | output | 1 | One-cycle pulse on command-driven wake |
| link_ready | output | 1 | Awake and past the exit window |

## Verification
The hardest case to reach from the ports is a wake request that arrives early, while the minimum-assertion window is still open. The stimulus gets the port asleep first, fires a single command strobe and then releases ticks one at a time. The number of ticks until the pin drops must equal the programmed minimum time exactly. The same tick-counting walk measures the exit window and the idle period for each row of a table of field settings. A separate sequence clears the enable bit mid-sleep to show that this exit produces no wake request.

// File: rtl/dslp_pkg.sv
package dslp_pkg;
   localparam int EN_BIT    = 0;
   localparam int PRES_BIT  = 1;
   localparam int EXIT_LSB  = 2;
   localparam int EXIT_W    = 8;
   localparam int HOLD_LSB  = 10;
   localparam int HOLD_W    = 5;
   localparam int IDLE_LSB  = 15;
   localparam int IDLE_W    = 10;
   localparam int MULT_LSB  = 25;
   localparam int MULT_W    = 4;
   localparam int WORD_W    = 32;

   typedef enum logic [1:0] {
      ST_AWAKE  = 2'd0,
      ST_ASLEEP = 2'd1,
      ST_LEAVE  = 2'd2
   } dslp_state_e;
endpackage

// File: rtl/dslp_sat_counter.sv
module dslp_sat_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (clr)             cnt <= '0;
      else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
   end

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt) == TOP && !$past(clr)) |-> cnt == TOP); // R5
endmodule

// File: rtl/dslp_ctrl_reg.sv
module dslp_ctrl_reg
   import dslp_pkg::*;
#(
   parameter bit                PRESENT  = 1'b1,
   parameter logic [EXIT_W-1:0] DEF_EXIT = 8'd20,
   parameter logic [HOLD_W-1:0] DEF_HOLD = 5'd10,
   parameter logic [IDLE_W-1:0] DEF_IDLE = 10'd1000,
   parameter logic [MULT_W-1:0] DEF_MULT = 4'd0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              engine_run,
   output logic              en,
   output logic [EXIT_W-1:0] exit_t,
   output logic [HOLD_W-1:0] hold_t,
   output logic [IDLE_W-1:0] idle_t,
   output logic [MULT_W-1:0] mult,
   output logic [WORD_W-1:0] rdata
);
   localparam int PAD_W = WORD_W - (MULT_LSB + MULT_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         exit_t <= DEF_EXIT;
         hold_t <= DEF_HOLD;
         idle_t <= DEF_IDLE;
         mult   <= DEF_MULT;
      end else if (wr) begin
         en <= wdata[EN_BIT];
         if (!engine_run) begin
            exit_t <= wdata[EXIT_LSB +: EXIT_W];
            hold_t <= wdata[HOLD_LSB +: HOLD_W];
            idle_t <= wdata[IDLE_LSB +: IDLE_W];
            mult   <= wdata[MULT_LSB +: MULT_W];
         end
      end
   end

   always_comb begin
      rdata = {{PAD_W{1'b0}}, mult, idle_t, hold_t, exit_t, PRESENT, en};
   end

   AST_LOCKED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && engine_run) |=> ($stable(exit_t) && $stable(hold_t)
                              && $stable(idle_t) && $stable(mult))); // R3
   AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> en == $past(wdata[EN_BIT])); // R4
endmodule

// File: rtl/dslp_idle_gate.sv
module dslp_idle_gate
   import dslp_pkg::*;
#(
   parameter bit PRESENT      = 1'b1,
   parameter bit SLUMBER_ONLY = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ms_tick,
   input  logic              en,
   input  logic              awake,
   input  logic              link_idle,
   input  logic              link_slumber,
   input  logic              cmd_issue,
   input  logic [IDLE_W-1:0] idle_t,
   input  logic [MULT_W-1:0] mult,
   output logic              entry_ok
);
   localparam int CNT_W = IDLE_W + MULT_W;

   logic             link_ok;
   logic             qual;
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] idle_cnt;

   generate
      if (SLUMBER_ONLY) begin : g_slumber
         assign link_ok = link_idle && link_slumber;
      end else begin : g_idle
         assign link_ok = link_idle;
      end
   endgenerate

   always_comb begin
      qual   = PRESENT && en && awake && link_ok;
      period = CNT_W'(idle_t) * (CNT_W'(mult) + CNT_W'(1));
   end

   dslp_sat_counter #(.W(CNT_W)) u_idle_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!qual || cmd_issue),
      .inc   (ms_tick),
      .cnt   (idle_cnt)
   );

   generate
      if (PRESENT) begin : g_present
         assign entry_ok = qual && !cmd_issue && (idle_t != '0) && (idle_cnt >= period);
      end else begin : g_absent
         assign entry_ok = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dslp_fsm.sv
module dslp_fsm
   import dslp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ms_tick,
   input  logic              en,
   input  logic              cmd_issue,
   input  logic              entry_ok,
   input  logic [HOLD_W-1:0] hold_t,
   input  logic [EXIT_W-1:0] exit_t,
   output logic              awake,
   output logic              dev_sleep,
   output logic              wake_req,
   output logic              link_ready
);
   localparam int TMR_W = (EXIT_W > HOLD_W) ? EXIT_W : HOLD_W;

   dslp_state_e state_q, state_d;
   logic             wake_pend_q;
   logic             wake_d;
   logic [TMR_W-1:0] tmr;
   logic             hold_met;
   logic             leave_req;

   always_comb begin
      hold_met  = tmr >= TMR_W'(hold_t);
      leave_req = wake_pend_q || cmd_issue || !en;
      state_d   = state_q;
      wake_d    = 1'b0;
      case (state_q)
         ST_AWAKE:  if (entry_ok) state_d = ST_ASLEEP;
         ST_ASLEEP: if (leave_req && hold_met) begin
                       state_d = ST_LEAVE;
                       wake_d  = wake_pend_q || cmd_issue;
                    end
         ST_LEAVE:  if (tmr >= TMR_W'(exit_t)) state_d = ST_AWAKE;
         default:   state_d = ST_AWAKE;
      endcase
   end

   dslp_sat_counter #(.W(TMR_W)) u_dwell (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   ((state_d != state_q) || (state_q == ST_AWAKE)),
      .inc   (ms_tick),
      .cnt   (tmr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_AWAKE;
         wake_pend_q <= 1'b0;
         wake_req    <= 1'b0;
      end else begin
         state_q  <= state_d;
         wake_req <= wake_d;
         if (state_q != ST_ASLEEP || state_d != ST_ASLEEP) wake_pend_q <= 1'b0;
         else if (cmd_issue)                                wake_pend_q <= 1'b1;
      end
   end

   always_comb begin
      awake      = (state_q == ST_AWAKE);
      dev_sleep  = (state_q == ST_ASLEEP);
      link_ready = awake;
   end

   AST_HOLD_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dev_sleep) |-> $past(tmr) >= TMR_W'($past(hold_t))); // R9
   AST_EXIT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_LEAVE) |=> !dev_sleep); // R10
endmodule

// File: rtl/dslp_port_ctrl.sv
module dslp_port_ctrl
   import dslp_pkg::*;
#(
   parameter bit                PRESENT      = 1'b1,
   parameter bit                SLUMBER_ONLY = 1'b0,
   parameter logic [EXIT_W-1:0] DEF_EXIT     = 8'd20,
   parameter logic [HOLD_W-1:0] DEF_HOLD     = 5'd10,
   parameter logic [IDLE_W-1:0] DEF_IDLE     = 10'd1000,
   parameter logic [MULT_W-1:0] DEF_MULT     = 4'd0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ms_tick,
   input  logic        engine_run,
   input  logic        link_idle,
   input  logic        link_slumber,
   input  logic        cmd_issue,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        dev_sleep,
   output logic        wake_req,
   output logic        link_ready
);
   generate
      if (MULT_LSB + MULT_W > WORD_W) begin : g_bad_layout
         $error("control word fields exceed word width");
      end
      if (IDLE_LSB + IDLE_W != MULT_LSB) begin : g_bad_order
         $error("idle and multiplier fields must abut");
      end
   endgenerate

   logic              en;
   logic              awake;
   logic              entry_ok;
   logic [EXIT_W-1:0] exit_t;
   logic [HOLD_W-1:0] hold_t;
   logic [IDLE_W-1:0] idle_t;
   logic [MULT_W-1:0] mult;

   dslp_ctrl_reg #(
      .PRESENT  (PRESENT),
      .DEF_EXIT (DEF_EXIT),
      .DEF_HOLD (DEF_HOLD),
      .DEF_IDLE (DEF_IDLE),
      .DEF_MULT (DEF_MULT)
   ) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .wdata      (reg_wdata),
      .engine_run (engine_run),
      .en         (en),
      .exit_t     (exit_t),
      .hold_t     (hold_t),
      .idle_t     (idle_t),
      .mult       (mult),
      .rdata      (reg_rdata)
   );

   dslp_idle_gate #(
      .PRESENT      (PRESENT),
      .SLUMBER_ONLY (SLUMBER_ONLY)
   ) u_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .ms_tick      (ms_tick),
      .en           (en),
      .awake        (awake),
      .link_idle    (link_idle),
      .link_slumber (link_slumber),
      .cmd_issue    (cmd_issue),
      .idle_t       (idle_t),
      .mult         (mult),
      .entry_ok     (entry_ok)
   );

   dslp_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .ms_tick    (ms_tick),
      .en         (en),
      .cmd_issue  (cmd_issue),
      .entry_ok   (entry_ok),
      .hold_t     (hold_t),
      .exit_t     (exit_t),
      .awake      (awake),
      .dev_sleep  (dev_sleep),
      .wake_req   (wake_req),
      .link_ready (link_ready)
   );

   generate
      if (!PRESENT) begin : g_chk_absent
         AST_ABSENT_NO_PIN: assert property (@(posedge clk) disable iff (!rst_n)
            !dev_sleep); // R7
      end
      if (SLUMBER_ONLY) begin : g_chk_slumber
         AST_SLUMBER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dev_sleep) |-> $past(link_slumber)); // R8
      end
   endgenerate

   AST_WAKE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> (!dev_sleep && $past(dev_sleep))); // R9
   AST_READY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
      link_ready |-> !dev_sleep); // R10
   AST_ENTRY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dev_sleep) |-> ($past(en) && $past(link_idle))); // R5
endmodule

// File: tb/tb_dslp_port_ctrl.sv
`timescale 1ns/1ps
module tb_dslp_port_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ms_tick = 1'b0, engine_run = 1'b0, link_idle = 1'b0;
   logic        link_slumber = 1'b1, cmd_issue = 1'b0, reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata, so_rdata, np_rdata;
   logic        dev_sleep, wake_req, link_ready;
   logic        so_sleep, so_wake, so_ready, np_sleep, np_wake, np_ready;

   always #4 clk = ~clk;

   dslp_port_ctrl dut (.clk, .rst_n, .ms_tick, .engine_run, .link_idle, .link_slumber,
      .cmd_issue, .reg_wr, .reg_wdata, .reg_rdata, .dev_sleep, .wake_req, .link_ready);
   dslp_port_ctrl #(.SLUMBER_ONLY(1'b1)) dut_so (.clk, .rst_n, .ms_tick, .engine_run,
      .link_idle, .link_slumber, .cmd_issue, .reg_wr, .reg_wdata, .reg_rdata(so_rdata),
      .dev_sleep(so_sleep), .wake_req(so_wake), .link_ready(so_ready));
   dslp_port_ctrl #(.PRESENT(1'b0)) dut_np (.clk, .rst_n, .ms_tick, .engine_run,
      .link_idle, .link_slumber, .cmd_issue, .reg_wr, .reg_wdata, .reg_rdata(np_rdata),
      .dev_sleep(np_sleep), .wake_req(np_wake), .link_ready(np_ready));

   int n_chk = 0, n_bad = 0, wake_cnt = 0, np_seen = 0;
   bit done = 0;

   always @(posedge clk) begin
      if (rst_n && wake_req) wake_cnt++;
      if (rst_n && np_sleep) np_seen++;
   end

   // fields {idle, mult, hold, exit}
   localparam logic [26:0] VEC [6] = '{
      {10'd3, 4'd0, 5'd0, 8'd0}, {10'd2, 4'd1, 5'd2, 8'd1},
      {10'd4, 4'd2, 5'd3, 8'd5}, {10'd1, 4'd3, 5'd1, 8'd2},
      {10'd5, 4'd0, 5'd4, 8'd0}, {10'd7, 4'd1, 5'd0, 8'd3}};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [31:0] word(input bit en, input int idle, input int mult,
                                        input int hold, input int ext);
      return (32'(mult) << 25) | (32'(idle) << 15) | (32'(hold) << 10) | (32'(ext) << 2) | 32'(en);
   endfunction

   task automatic tick();
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk) begin reg_wr = 1'b1; reg_wdata = d; end
      @(negedge clk) reg_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_cmd();
      @(negedge clk) cmd_issue = 1'b1;
      @(negedge clk) cmd_issue = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic ticks_until_sleep(input logic lvl, output int n);
      n = 0;
      while (dev_sleep !== lvl && n < 300) begin tick(); n++; end
   endtask

   task automatic ticks_until_ready(output int n);
      n = 0;
      while (link_ready !== 1'b1 && n < 300) begin tick(); n++; end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int n, w0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1, R2: reset state and default layout
      check(reg_rdata == word(0, 1000, 0, 10, 20) + 32'd2, "R1 rdata", reg_rdata, word(0, 1000, 0, 10, 20) + 32'd2);
      check(!dev_sleep && !wake_req, "R1 pins", dev_sleep, 0);
      check(link_ready, "R1 ready", link_ready, 1);
      check(np_rdata[1] == 1'b0, "R7 present bit", np_rdata[1], 0);

      // table walk: R2 R5 R9 R10
      for (int i = 0; i < 6; i++) begin
         int idle, mult, hold, ext, per;
         idle = VEC[i][26:17]; mult = VEC[i][16:13]; hold = VEC[i][12:8]; ext = VEC[i][7:0];
         per = idle * (mult + 1);
         link_idle = 1'b0;
         wr(word(1, idle, mult, hold, ext));
         check(reg_rdata == word(1, idle, mult, hold, ext) + 32'd2, "R2 readback", reg_rdata, word(1, idle, mult, hold, ext) + 32'd2);
         link_idle = 1'b1;
         ticks_until_sleep(1'b1, n);
         check(n == per, "R5 entry ticks", n, per);
         w0 = wake_cnt;
         pulse_cmd();
         ticks_until_sleep(1'b0, n);
         check(n == hold, "R9 hold ticks", n, hold);
         check(wake_cnt == w0 + 1, "R9 wake pulse", wake_cnt - w0, 1);
         ticks_until_ready(n);
         check(n == ext, "R10 exit ticks", n, ext);
         check(!dev_sleep, "R10 no reentry", dev_sleep, 0);
         link_idle = 1'b0;
         @(negedge clk);
      end

      // R3, R4: locked timing fields, free enable
      wr(word(1, 6, 0, 0, 0));
      engine_run = 1'b1;
      wr(word(0, 9, 3, 7, 11));
      check(reg_rdata == word(0, 6, 0, 0, 0) + 32'd2, "R3 locked", reg_rdata, word(0, 6, 0, 0, 0) + 32'd2);
      check(reg_rdata[0] == 1'b0, "R4 enable clear while running", reg_rdata[0], 0);
      wr(word(1, 9, 3, 7, 11));
      check(reg_rdata[0] == 1'b1, "R4 enable set while running", reg_rdata[0], 1);
      engine_run = 1'b0;
      wr(word(1, 6, 0, 0, 0));
      check(reg_rdata == word(1, 6, 0, 0, 0) + 32'd2, "R3 unlocked", reg_rdata, word(1, 6, 0, 0, 0) + 32'd2);

      // R6: restart on command and on idle drop
      link_idle = 1'b1;
      repeat (4) tick();
      pulse_cmd();
      ticks_until_sleep(1'b1, n);
      check(n == 6, "R6 restart on cmd", n, 6);
      pulse_cmd();
      repeat (3) tick();
      link_idle = 1'b0;
      @(negedge clk);
      link_idle = 1'b1;
      ticks_until_sleep(1'b1, n);
      check(n == 6, "R6 restart on idle drop", n, 6);
      pulse_cmd();
      link_idle = 1'b0;

      // R5: idle time 0 never enters
      wr(word(1, 0, 2, 0, 0));
      link_idle = 1'b1;
      repeat (20) tick();
      check(!dev_sleep, "R5 zero idle time", dev_sleep, 0);
      link_idle = 1'b0;

      // R8: slumber-only strap
      wr(word(1, 3, 0, 0, 0));
      link_slumber = 1'b0;
      link_idle = 1'b1;
      repeat (5) tick();
      check(dev_sleep, "R8 plain port enters", dev_sleep, 1);
      check(!so_sleep, "R8 strapped port waits", so_sleep, 0);
      link_slumber = 1'b1;
      repeat (3) tick();
      check(so_sleep, "R8 strapped port in slumber", so_sleep, 1);
      pulse_cmd();
      check(!dev_sleep && !so_sleep, "R8 both woken", dev_sleep | so_sleep, 0);
      link_idle = 1'b0;

      // R11: disable while asleep
      wr(word(1, 2, 0, 3, 2));
      link_idle = 1'b1;
      ticks_until_sleep(1'b1, n);
      link_idle = 1'b0;
      w0 = wake_cnt;
      wr(word(0, 2, 0, 3, 2));
      check(dev_sleep, "R11 held by min time", dev_sleep, 1);
      ticks_until_sleep(1'b0, n);
      check(n == 3, "R11 hold ticks", n, 3);
      check(wake_cnt == w0, "R11 no wake", wake_cnt - w0, 0);
      ticks_until_ready(n);
      check(n == 2, "R11 exit ticks", n, 2);

      // R7: absent pin never rose
      check(np_seen == 0, "R7 never asserted", np_seen, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule